// File: doc/BRIEF.md
# Multi-channel playback command decoder

This block turns a stream of command bytes, as delivered by a serial receiver, into the control state of a small voice playback engine. Each accepted byte arrives as a one-cycle `cmd_valid` pulse with the byte on `cmd_byte`. Some commands are one byte long. Others take a second operand byte. The decoder keeps a global power state with a double-entry flag. For each channel it keeps a 10-bit phrase number, an active flag, a repeat flag and a 5-bit volume.

The playback engine reads these registers directly. It also receives a one-cycle start or stop pulse for every channel that a command starts or stops. A start that carries no phrase replays the phrase most recently stored for that channel. A stop also cancels repeat mode. Channel selection is either a single channel bit (phrase commands) or a two-bit mask (start, stop, repeat and volume), so one command can act on both channels at once. A status byte reports which channels are active.

All register outputs and pulses change on the clock edge that accepts the byte completing a command. They are visible one cycle after that byte is presented.

Top module: `voice_cmd_decoder`

## Requirements
- R1: A byte whose upper seven bits are zero (0x00 or 0x01) powers the block up and copies bit 0 into `dbl_entry`. Byte 0x20 powers it down and clears the active and repeat flags of every channel, without issuing pulses.
- R2: While powered down, every byte other than 0x00/0x01 is ignored, including the first byte of a two-byte command.
- R3: Play is the byte pair {0100 0 c p9 p8} followed by {p7..p0}. It stores phrase {p9..p0} into channel c (bit 2 of the first byte), sets that channel active and pulses its start line.
- R4: Phrase-set is the byte pair {0011 0 c p9 p8} followed by {p7..p0}. It stores the phrase the same way, but does not change the active flag and gives no pulse.
- R5: Start is 0101 00 m1 m0. Each channel whose mask bit is set (m0 = channel 0) becomes active and gets a start pulse, and its stored phrase is kept.
- R6: Stop is 0110 00 m1 m0. Each selected channel gets a stop pulse and has its active and repeat flags cleared.
- R7: 1000 00 m1 m0 sets the repeat flag of each selected channel, and 1001 00 m1 m0 clears it.
- R8: Volume is 1010 00 m1 m0 followed by an operand byte. Bits 4:0 of the operand become the volume of every selected channel, with 0 meaning off. Operand bits 7:5 have no effect.
- R9: The byte after the first byte of a two-byte command is always taken as its operand, whatever its value.
- R10: Any other byte, including the listed opcodes with a nonzero reserved bit (bit 3 of the phrase commands, bits 3:2 of the mask commands), leaves every output unchanged.
- R11: After reset the block is powered down with `dbl_entry` 0, all phrases 0, no channel active, no repeat flag set, every volume 31 and no pulses.
- R12: Bit i of `busy_status` equals the active flag of channel i, and the unused bits read 0. Every output changes on the cycle after the byte completing a command, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a received byte |
| cmd_byte | input | 8 | Received command or operand byte |
| pwr_on | output | 1 | Block is powered up |
| dbl_entry | output | 1 | Double-entry mode flag, as stored by power-up |
| start_pulse | output | NCH | Per-channel start pulse |
| stop_pulse | output | NCH | Per-channel stop pulse |
| ch_active | output | NCH | Per-channel active flag |
| ch_loop | output | NCH | Per-channel repeat flag |
| ch_phrase | output | NCH*10 | Stored phrase numbers, channel i at bits [10i+9:10i] |
| ch_volume | output | NCH*5 | Channel volumes, channel i at bits [5i+4:5i] |
| busy_status | output | 8 | Active flag per channel, upper bits zero |

## Verification
Bytes are sent while the block is powered down, to show that the power gate also blocks the start of two-byte commands. Play commands are sent to each channel with boundary phrase numbers (0x2A5 and 0x3FF), so the bits split across the two bytes and the channel bit are all tested. Mask commands are sent with single-channel and dual-channel masks, to tell per-channel selection apart from broadcast. Operands that look like opcodes (0x20, 0x00) and opcodes with reserved bits set separate the operand rule from the unknown-opcode rule. Bytes sent back to back, with no idle cycle between them, expose any cycle slip in the parser.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  localparam int PHR_W = 10;
  localparam int VOL_W = 5;
  localparam int SEL_W = 2;
  localparam logic [VOL_W-1:0] VOL_RST = '1;

  typedef enum logic [3:0] {
    EV_NONE, EV_PWRUP, EV_PWRDN, EV_PLAY, EV_SETPH,
    EV_START, EV_STOP, EV_LSET, EV_LCLR, EV_VOL
  } ev_kind_t;

  typedef struct packed {
    ev_kind_t          kind;
    logic [SEL_W-1:0]  sel;
    logic [PHR_W-1:0]  phrase;
    logic [VOL_W-1:0]  vol;
  } cmd_ev_t;

  // first byte of a command that expects an operand byte
  function automatic logic wants_operand(input logic [7:0] b);
    return (b[7:3] == 5'b01000) || (b[7:3] == 5'b00110) || (b[7:2] == 6'b101000);
  endfunction

  // decode of a complete one-byte command (power-up handled elsewhere)
  function automatic ev_kind_t single_kind(input logic [7:0] b);
    ev_kind_t k;
    k = EV_NONE;
    if (b == 8'h20) k = EV_PWRDN;
    else if (b[3:2] == 2'b00) begin
      case (b[7:4])
        4'h5:    k = EV_START;
        4'h6:    k = EV_STOP;
        4'h8:    k = EV_LSET;
        4'h9:    k = EV_LCLR;
        default: k = EV_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/vcd_parser.sv
module vcd_parser
  import vcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output cmd_ev_t    ev,
  output logic       pwr_on,
  output logic       dbl_entry
);

  logic       pend_q, pend_d;
  logic [7:0] first_q;
  logic       first_en;
  logic       pwr_q, pwr_d;
  logic       dbl_q, dbl_d;

  always_comb begin
    ev       = '{kind: EV_NONE, sel: '0, phrase: '0, vol: '0};
    pend_d   = pend_q;
    first_en = 1'b0;
    pwr_d    = pwr_q;
    dbl_d    = dbl_q;
    if (cmd_valid) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (first_q[7:3] == 5'b01000 || first_q[7:3] == 5'b00110) begin
          ev.kind   = (first_q[7:4] == 4'h4) ? EV_PLAY : EV_SETPH;
          ev.sel    = first_q[2] ? 2'b10 : 2'b01;
          ev.phrase = {first_q[1:0], cmd_byte};
        end else if (first_q[7:2] == 6'b101000) begin
          ev.kind = EV_VOL;
          ev.sel  = first_q[1:0];
          ev.vol  = cmd_byte[VOL_W-1:0];
        end
      end else if (cmd_byte[7:1] == 7'd0) begin
        ev.kind = EV_PWRUP;
        pwr_d   = 1'b1;
        dbl_d   = cmd_byte[0];
      end else if (pwr_q) begin
        if (wants_operand(cmd_byte)) begin
          pend_d   = 1'b1;
          first_en = 1'b1;
        end else begin
          ev.kind = single_kind(cmd_byte);
          ev.sel  = cmd_byte[1:0];
          if (ev.kind == EV_PWRDN) pwr_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      first_q <= '0;
      pwr_q   <= 1'b0;
      dbl_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pwr_q  <= pwr_d;
      dbl_q  <= dbl_d;
      if (first_en) first_q <= cmd_byte;
    end
  end

  assign pwr_on    = pwr_q;
  assign dbl_entry = dbl_q;

endmodule

// File: rtl/vcd_chan.sv
module vcd_chan
  import vcd_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_ev_t          ev,
  output logic             active,
  output logic             looping,
  output logic             start_p,
  output logic             stop_p,
  output logic [PHR_W-1:0] phrase,
  output logic [VOL_W-1:0] vol
);

  localparam bit SELECTABLE = (IDX < SEL_W);
  localparam int SEL_BIT    = SELECTABLE ? IDX : 0;

  logic             hit;
  logic             act_q, act_d, loop_q, loop_d;
  logic             start_d, stop_d, start_q, stop_q;
  logic             phr_en, vol_en;
  logic [PHR_W-1:0] phr_q;
  logic [VOL_W-1:0] vol_q;

  assign hit = SELECTABLE && ev.sel[SEL_BIT];

  always_comb begin
    act_d   = act_q;
    loop_d  = loop_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    phr_en  = 1'b0;
    vol_en  = 1'b0;
    if (ev.kind == EV_PWRDN) begin
      act_d  = 1'b0;
      loop_d = 1'b0;
    end else if (hit) begin
      case (ev.kind)
        EV_PLAY: begin
          phr_en  = 1'b1;
          act_d   = 1'b1;
          start_d = 1'b1;
        end
        EV_SETPH: phr_en = 1'b1;
        EV_START: begin
          act_d   = 1'b1;
          start_d = 1'b1;
        end
        EV_STOP: begin
          act_d  = 1'b0;
          loop_d = 1'b0;
          stop_d = 1'b1;
        end
        EV_LSET: loop_d = 1'b1;
        EV_LCLR: loop_d = 1'b0;
        EV_VOL:  vol_en = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      loop_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      phr_q   <= '0;
      vol_q   <= VOL_RST;
    end else begin
      act_q   <= act_d;
      loop_q  <= loop_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      if (phr_en) phr_q <= ev.phrase;
      if (vol_en) vol_q <= ev.vol;
    end
  end

  assign active  = act_q;
  assign looping = loop_q;
  assign start_p = start_q;
  assign stop_p  = stop_q;
  assign phrase  = phr_q;
  assign vol     = vol_q;

endmodule

// File: rtl/voice_cmd_decoder.sv
module voice_cmd_decoder
  import vcd_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_byte,
  output logic               pwr_on,
  output logic               dbl_entry,
  output logic [NCH-1:0]     start_pulse,
  output logic [NCH-1:0]     stop_pulse,
  output logic [NCH-1:0]     ch_active,
  output logic [NCH-1:0]     ch_loop,
  output logic [NCH*PHR_W-1:0] ch_phrase,
  output logic [NCH*VOL_W-1:0] ch_volume,
  output logic [7:0]         busy_status
);

  cmd_ev_t ev;

  vcd_parser u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .ev        (ev),
    .pwr_on    (pwr_on),
    .dbl_entry (dbl_entry)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    vcd_chan #(.IDX(i)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .active  (ch_active[i]),
      .looping (ch_loop[i]),
      .start_p (start_pulse[i]),
      .stop_p  (stop_pulse[i]),
      .phrase  (ch_phrase[i*PHR_W +: PHR_W]),
      .vol     (ch_volume[i*VOL_W +: VOL_W])
    );
  end

  always_comb begin
    busy_status          = '0;
    busy_status[NCH-1:0] = ch_active;
  end

endmodule

// File: rtl/voice_cmd_decoder_chk.sv
module voice_cmd_decoder_chk
  import vcd_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [7:0]           cmd_byte,
  input logic                 pwr_on,
  input logic [NCH-1:0]       start_pulse,
  input logic [NCH-1:0]       stop_pulse,
  input logic [NCH-1:0]       ch_active,
  input logic [NCH-1:0]       ch_loop,
  input logic [NCH*PHR_W-1:0] ch_phrase
);

  // R1
  pwr_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> ($past(cmd_valid) && (($past(cmd_byte) >> 1) == 8'd0)));

  // R2
  down_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (start_pulse == '0 && stop_pulse == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse[i] |-> (!ch_active[i] && !ch_loop[i]));
    // R5
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[i] |-> (ch_active[i] && !stop_pulse[i]));
    // R12
    phrase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_valid) |-> $stable(ch_phrase[i*PHR_W +: PHR_W]));
  end

endmodule

bind voice_cmd_decoder voice_cmd_decoder_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_byte    (cmd_byte),
  .pwr_on      (pwr_on),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .ch_active   (ch_active),
  .ch_loop     (ch_loop),
  .ch_phrase   (ch_phrase)
);

// File: tb/test_voice_cmd_decoder.sv
module test_voice_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [7:0]        cmd_byte;
  logic              pwr_on, dbl_entry;
  logic [NCH-1:0]    start_pulse, stop_pulse, ch_active, ch_loop;
  logic [NCH*10-1:0] ch_phrase;
  logic [NCH*5-1:0]  ch_volume;
  logic [7:0]        busy_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_cmd_decoder #(.NCH(NCH)) i_voice_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pwr_on(pwr_on), .dbl_entry(dbl_entry), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .ch_active(ch_active), .ch_loop(ch_loop),
    .ch_phrase(ch_phrase), .ch_volume(ch_volume), .busy_status(busy_status)
  );

  // behavioural reference model
  int m_pwr, m_dbl, m_pend, m_first;
  int m_phr[NCH], m_act[NCH], m_loop[NCH], m_vol[NCH], m_st[NCH], m_sp[NCH];

  task automatic model_reset();
    m_pwr = 0; m_dbl = 0; m_pend = 0; m_first = 0;
    for (int c = 0; c < NCH; c++) begin
      m_phr[c] = 0; m_act[c] = 0; m_loop[c] = 0; m_vol[c] = 31; m_st[c] = 0; m_sp[c] = 0;
    end
  endtask

  task automatic model_byte(input int b);
    int hi, lo, ch;
    hi = b / 16;
    lo = b % 16;
    if (m_pend != 0) begin
      m_pend = 0;
      if (m_first / 16 == 4 || m_first / 16 == 3) begin
        ch = (m_first / 4) % 2;
        m_phr[ch] = (m_first % 4) * 256 + b;
        if (m_first / 16 == 4) begin m_act[ch] = 1; m_st[ch] = 1; end
      end else begin
        for (int c = 0; c < NCH; c++)
          if (((m_first >> c) & 1) == 1) m_vol[c] = b % 32;
      end
    end else if (b < 2) begin
      m_pwr = 1; m_dbl = b;
    end else if (m_pwr != 0) begin
      if ((hi == 4 || hi == 3) && lo < 8) begin m_pend = 1; m_first = b; end
      else if (hi == 10 && lo < 4) begin m_pend = 1; m_first = b; end
      else if (b == 32) begin
        m_pwr = 0;
        for (int c = 0; c < NCH; c++) begin m_act[c] = 0; m_loop[c] = 0; end
      end else if (lo < 4) begin
        for (int c = 0; c < NCH; c++) begin
          if (((lo >> c) & 1) == 1) begin
            case (hi)
              5: begin m_act[c] = 1; m_st[c] = 1; end
              6: begin m_act[c] = 0; m_loop[c] = 0; m_sp[c] = 1; end
              8: m_loop[c] = 1;
              9: m_loop[c] = 0;
              default: ;
            endcase
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_sp[c] = 0; end
      if (cmd_valid) model_byte(int'(cmd_byte));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R1 pwr_on", int'(pwr_on), m_pwr);
      chk("R1 dbl_entry", int'(dbl_entry), m_dbl);
      for (int c = 0; c < NCH; c++) begin
        chk("R3/R4 phrase", int'(ch_phrase[c*10 +: 10]), m_phr[c]);
        chk("R5 active", int'(ch_active[c]), m_act[c]);
        chk("R5 start pulse", int'(start_pulse[c]), m_st[c]);
        chk("R6 stop pulse", int'(stop_pulse[c]), m_sp[c]);
        chk("R7 loop", int'(ch_loop[c]), m_loop[c]);
        chk("R8 volume", int'(ch_volume[c*5 +: 5]), m_vol[c]);
      end
      chk("R12 status", int'(busy_status), m_act[0] + 2 * m_act[1]);
    end
  end

  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    @(negedge clk);
  endtask

  task automatic send_burst(input logic [7:0] a, input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_byte  = a;
    @(negedge clk);
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R11: reset values, fixed expectations
    chk("R11 pwr", int'(pwr_on), 0);
    chk("R11 phrase", int'(ch_phrase), 0);
    chk("R11 volume", int'(ch_volume), 1023);
    chk("R11 active", int'(ch_active), 0);
    chk("R11 pulses", int'(start_pulse) + int'(stop_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: powered down, everything but power-up ignored
    send(8'h41); send(8'h23); send(8'h53); send(8'hA3); send(8'h05);
    // R1: power up, double-entry then plain
    send(8'h01); send(8'h00);
    // R3: play both channels, boundary phrases
    send(8'h42); send(8'hA5);
    send_burst(8'h47, 8'hFF);
    // R4: phrase-set without start
    send(8'h30); send(8'h01);
    // R6 then R5 replay
    send(8'h63); send(8'h53);
    send(8'h62);
    // R7 loop set/clear, stop clears loop
    send(8'h83); send(8'h91); send(8'h61); send(8'h83);
    // R8 volume, upper operand bits ignored
    send(8'hA3); send(8'hE7);
    send(8'hA1); send(8'h1F);
    // R9: operands that look like commands
    send(8'hA2); send(8'h20);
    send(8'h46); send(8'h00);
    // R10: unknown or reserved-bit opcodes
    send(8'h5C); send(8'hFF); send(8'h10); send(8'h48); send(8'h21);
    send(8'h6F); send(8'h8C); send(8'hA4); send(8'h02);
    // R1: power down with active channels, then back up
    send(8'h53); send(8'h83);
    send(8'h20);
    send(8'h52);
    send(8'h01);
    send_burst(8'h51, 8'h62);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule